// File: doc/BRIEF.md
# J2 Path Trace Checker

This block checks the low-order path trace that travels one byte per VC-12 multiframe. Each accepted byte is offered on a valid/ready stream. The block assembles the bytes into a 16-byte trace frame and finds the frame start from the top bit of each byte. When the frame is complete it checks the CRC-7 carried in the header byte against the content of the whole frame.

A frame whose CRC is correct is kept as the last accepted trace, for software to read back. It is also compared with an expected 16-byte string held outside the block. A persistent difference between the two raises a trace-mismatch alarm. The alarm produces an AIS request unless a mask input is set. Frames with a bad CRC leave the alarm and its history exactly as they were.

The byte stream has simple back-pressure rules. `in_ready` is low while reset is held and high at every other time. A byte is taken on each rising edge where `in_valid` and `in_ready` are both high. The sender may pause at any time by lowering `in_valid`.

Top module: `j2_trace_chk`

## Requirements
- R1: While `rst_n` is low, `alarm`, `ais_req`, `in_ready` and `acc_trace` are all 0.
- R2: `in_ready` is 1 whenever reset is released. A byte is taken only on an edge where `in_valid` is 1, and idle cycles between bytes do not disturb frame assembly.
- R3: A byte with bit 7 set always starts a new frame as byte 0, and any partial frame is thrown away. Bytes with bit 7 clear fill positions 1 to 15. A bit-7-clear byte that arrives while no frame is open is ignored, so alignment is lost after a complete frame until the next bit-7-set byte.
- R4: The CRC-7 uses polynomial x^7+x^3+1 with an initial value of 0, processing each byte MSB first. It covers all 16 bytes, with the low 7 bits of byte 0 taken as zero. The result must equal bits 6:0 of byte 0.
- R5: A frame whose CRC is correct appears on `acc_trace` on the second rising edge after its last byte is taken. Byte 0 sits in bits 127:120 and byte 15 in bits 7:0.
- R6: A frame with a bad CRC changes neither `acc_trace`, `alarm`, nor the consecutive-frame counts.
- R7: `alarm` sets after 3 consecutive CRC-valid frames that differ from `exp_trace`, where all 128 bits are compared in the same layout as `acc_trace`.
- R8: `alarm` clears after 3 consecutive CRC-valid frames that equal `exp_trace`. A CRC-valid frame of the opposite kind restarts the count.
- R9: `ais_req` is 1 exactly when `alarm` is 1 and `ais_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Trace byte present |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Trace byte |
| exp_trace | input | 128 | Expected 16-byte string |
| ais_mask | input | 1 | 1 blocks the AIS request |
| alarm | output | 1 | Trace-mismatch alarm |
| ais_req | output | 1 | AIS consequent action request |
| acc_trace | output | 128 | Last CRC-valid trace frame |

## Verification
The assertions assume two things about the inputs. First, reset is low at the first clock edge. Second, `exp_trace` stays steady while a frame is being judged, because the alarm history is only meaningful against a fixed expected string. The bench drives `rst_n` low from time zero and keeps `exp_trace` constant for the whole run. It changes `in_valid`, `in_byte` and `ais_mask` only on falling edges, so every rising edge sees settled inputs.

// File: rtl/j2t_pkg.sv
package j2t_pkg;
  localparam logic [6:0] CRC7_POLY = 7'h09;

  function automatic logic [6:0] crc7_step(input logic [6:0] cur, input logic [7:0] din);
    logic [6:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[6] ^ din[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ CRC7_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/j2t_align.sv
module j2t_align #(
  parameter int NBYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_in,
  output logic                  hdr_take,
  output logic                  pay_take,
  output logic                  frame_done,
  output logic [NBYTES*8-1:0]   frame_q
);
  localparam int FW   = NBYTES * 8;
  localparam int IDXW = $clog2(NBYTES);
  localparam logic [IDXW-1:0] LAST = IDXW'(NBYTES - 1);

  logic [IDXW-1:0] idx_q;
  logic            open_q;

  assign hdr_take = byte_vld && byte_in[7];
  assign pay_take = byte_vld && !byte_in[7] && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      open_q     <= 1'b0;
      frame_done <= 1'b0;
      frame_q    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (hdr_take) begin
        frame_q <= {{(FW-8){1'b0}}, byte_in};
        idx_q   <= IDXW'(1);
        open_q  <= 1'b1;
      end else if (pay_take) begin
        frame_q <= {frame_q[FW-9:0], byte_in};
        if (idx_q == LAST) begin
          idx_q      <= '0;
          open_q     <= 1'b0;
          frame_done <= 1'b1;
        end else begin
          idx_q <= idx_q + IDXW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/j2t_crc7.sv
module j2t_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_take,
  input  logic       pay_take,
  input  logic [7:0] byte_in,
  output logic       crc_ok
);
  import j2t_pkg::*;

  logic [6:0] crc_q;
  logic [6:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      rx_q  <= '0;
    end else if (hdr_take) begin
      crc_q <= crc7_step(7'd0, {byte_in[7], 7'd0});
      rx_q  <= byte_in[6:0];
    end else if (pay_take) begin
      crc_q <= crc7_step(crc_q, byte_in);
    end
  end

  assign crc_ok = (crc_q == rx_q);
endmodule

// File: rtl/j2t_judge.sv
module j2t_judge #(
  parameter int NBYTES  = 16,
  parameter int PERSIST = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic                crc_ok,
  input  logic [NBYTES*8-1:0] frame,
  input  logic [NBYTES*8-1:0] expect_v,
  output logic                alarm,
  output logic [NBYTES*8-1:0] acc_trace
);
  localparam int CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] FULL = CW'(PERSIST);
  localparam logic [CW-1:0] EDGE = CW'(PERSIST - 1);

  logic [NBYTES-1:0] byte_eq;
  logic              same;
  logic [CW-1:0]     mis_q, ok_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
    assign byte_eq[g] = (frame[g*8 +: 8] == expect_v[g*8 +: 8]);
  end
  assign same = &byte_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_q     <= '0;
      ok_q      <= '0;
      alarm     <= 1'b0;
      acc_trace <= '0;
    end else if (frame_done && crc_ok) begin
      acc_trace <= frame;
      if (same) begin
        mis_q <= '0;
        if (ok_q != FULL) ok_q <= ok_q + CW'(1);
        if (ok_q >= EDGE) alarm <= 1'b0;
      end else begin
        ok_q <= '0;
        if (mis_q != FULL) mis_q <= mis_q + CW'(1);
        if (mis_q >= EDGE) alarm <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/j2_trace_chk.sv
module j2_trace_chk #(
  parameter int NBYTES  = 16,
  parameter int PERSIST = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_byte,
  input  logic [NBYTES*8-1:0] exp_trace,
  input  logic                ais_mask,
  output logic                alarm,
  output logic                ais_req,
  output logic [NBYTES*8-1:0] acc_trace
);
  localparam int FW = NBYTES * 8;

  logic          rdy_q;
  logic          byte_vld;
  logic          hdr_w, pay_w, done_w, crc_ok_w;
  logic [FW-1:0] frame_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;
  assign byte_vld = in_valid && rdy_q;

  j2t_align #(.NBYTES(NBYTES)) u_align (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(in_byte),
    .hdr_take(hdr_w), .pay_take(pay_w), .frame_done(done_w), .frame_q(frame_w)
  );

  j2t_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .hdr_take(hdr_w), .pay_take(pay_w),
    .byte_in(in_byte), .crc_ok(crc_ok_w)
  );

  j2t_judge #(.NBYTES(NBYTES), .PERSIST(PERSIST)) u_judge (
    .clk(clk), .rst_n(rst_n), .frame_done(done_w), .crc_ok(crc_ok_w),
    .frame(frame_w), .expect_v(exp_trace), .alarm(alarm), .acc_trace(acc_trace)
  );

  assign ais_req = alarm && !ais_mask;
endmodule

// File: rtl/j2t_checker.sv
module j2t_checker #(
  parameter int NBYTES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                ais_mask,
  input logic                alarm,
  input logic                ais_req,
  input logic [NBYTES*8-1:0] acc_trace,
  input logic                frame_done,
  input logic                crc_ok,
  input logic [NBYTES*8-1:0] frame_q
);
  logic [NBYTES-2:0] tail_msb;
  always_comb begin
    for (int k = 0; k < NBYTES - 1; k++) tail_msb[k] = frame_q[k*8 + 7];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!alarm && !in_ready && acc_trace == '0));

  // R3
  frame_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_q[NBYTES*8-1] && tail_msb == '0));

  // R5
  trace_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_trace) |-> $past(frame_done && crc_ok));

  // R6
  alarm_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm) |-> $past(frame_done && crc_ok));

  // R9
  ais_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ais_mask |-> !ais_req);
endmodule

bind j2_trace_chk j2t_checker #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ais_mask(ais_mask),
  .alarm(alarm), .ais_req(ais_req), .acc_trace(acc_trace),
  .frame_done(done_w), .crc_ok(crc_ok_w), .frame_q(frame_w)
);

// File: tb/sim_j2_trace_chk.sv
module sim_j2_trace_chk;
  localparam int FW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_byte = '0;
  logic [FW-1:0] exp_trace;
  logic          ais_mask = 1'b0;
  logic          alarm, ais_req;
  logic [FW-1:0] acc_trace;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  j2_trace_chk u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .exp_trace(exp_trace), .ais_mask(ais_mask),
    .alarm(alarm), .ais_req(ais_req), .acc_trace(acc_trace)
  );

  // kind in [2:1]: 0 match, 1 mismatch, 2 bad-CRC match, 3 bad-CRC mismatch; [0] alarm after
  localparam logic [2:0] VEC [14] = '{
    3'b010, 3'b010, 3'b011, 3'b101, 3'b001, 3'b011, 3'b001,
    3'b001, 3'b000, 3'b110, 3'b010, 3'b010, 3'b100, 3'b011
  };

  function automatic logic [FW-1:0] seal(input logic [119:0] pay);
    logic [FW-1:0] v;
    logic [6:0] c;
    logic fb;
    v = {8'h80, pay};
    c = '0;
    for (int i = FW - 1; i >= 0; i--) begin
      fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    v[126:120] = c;
    return v;
  endfunction

  task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [FW-1:0] f, input int gap);
    for (int k = 0; k < 16; k++) send_byte(f[FW-1-8*k -: 8], gap);
  endtask

  logic [FW-1:0] fa, fb_, fa_bad, fb_bad, last_ok, pick;
  logic [119:0]  pa, pb;

  initial begin
    for (int k = 0; k < 15; k++) begin
      pa[119-8*k -: 8] = 8'h41 + 8'(k);
      pb[119-8*k -: 8] = 8'h61 + 8'(k);
    end
    fa = seal(pa);
    fb_ = seal(pb);
    fa_bad = fa ^ {8'h01, 120'd0};
    fb_bad = fb_ ^ {8'h01, 120'd0};
    exp_trace = fa;
    last_ok = '0;

    repeat (3) @(negedge clk);
    check("R1 alarm in reset", FW'(alarm), '0);
    check("R1 ready in reset", FW'(in_ready), '0);
    check("R1 trace in reset", acc_trace, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 ready after reset", FW'(in_ready), FW'(1));

    for (int r = 0; r < 14; r++) begin
      case (VEC[r][2:1])
        2'd0: pick = fa;
        2'd1: pick = fb_;
        2'd2: pick = fa_bad;
        default: pick = fb_bad;
      endcase
      send_frame(pick, 0);
      if (!VEC[r][2]) last_ok = pick;
      @(negedge clk);
      @(negedge clk);
      check(VEC[r][2] ? "R6 alarm" : (VEC[r][1] ? "R7 alarm" : "R8 alarm"),
            FW'(alarm), FW'(VEC[r][0]));
      check(VEC[r][2] ? "R6 trace" : "R4/R5 trace", acc_trace, last_ok);
      check("R9 ais follows alarm", FW'(ais_req), FW'(VEC[r][0]));
    end

    // R9 masking
    ais_mask = 1'b1;
    @(negedge clk);
    check("R9 masked", FW'(ais_req), '0);
    check("R9 alarm kept", FW'(alarm), FW'(1));
    ais_mask = 1'b0;
    @(negedge clk);
    check("R9 unmasked", FW'(ais_req), FW'(1));

    // R3 stray bytes, then a header cutting a partial frame
    for (int k = 0; k < 3; k++) send_byte(8'h05, 0);
    for (int k = 0; k < 7; k++) send_byte(fb_[FW-1-8*k -: 8], 0);
    send_frame(fa, 0);
    @(negedge clk);
    @(negedge clk);
    check("R3 restart trace", acc_trace, fa);
    check("R3 alarm held", FW'(alarm), FW'(1));
    send_frame(fa, 0);
    send_frame(fa, 0);
    @(negedge clk);
    @(negedge clk);
    check("R8 cleared after realign", FW'(alarm), '0);

    // R2 gaps and R5 timing
    send_frame(fb_, 2);
    @(negedge clk);
    check("R5 not yet", acc_trace, fa);
    @(negedge clk);
    check("R2 gapped frame", acc_trace, fb_);

    // R1 reset mid-run
    send_frame(fb_, 0);
    send_frame(fb_, 0);
    @(negedge clk);
    @(negedge clk);
    check("R7 alarm before reset", FW'(alarm), FW'(1));
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 alarm cleared", FW'(alarm), '0);
    check("R1 trace cleared", acc_trace, '0);
    check("R1 ready low", FW'(in_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 ready again", FW'(in_ready), FW'(1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule